// File: doc/BRIEF.md
# Fault-Injectable Single-Port RAM

This block is a small synchronous single-port RAM meant as a target for developing and checking memory self-test sequences. It has an ordinary address, write enable, write data and registered read data. A separate configuration port lets a test harness turn one bit of one word into a faulty cell. The chosen fault follows one of the static single-cell fault primitives: stuck at a constant, a failed rising or falling transition, or a flip caused by rewriting the value the cell already holds.

Each write to the targeted word is judged bit by bit against the value that word held before the edge. The targeted bit stores the result that the selected fault primitive gives. Every other bit, and every other word, takes the written value unchanged. A stuck-at fault also overrides the targeted bit on the read path. A read therefore shows the stuck value even if the cell held something else before the fault was armed. Reads have one cycle of latency and return the word as it was before a write in the same cycle.

Top module: `fault_ram`

## Requirements
- R1: The reset input `rstN` is active low and asynchronous. While it is low, every word is cleared to zero, `rdData` is cleared to zero and the fault selection returns to "no fault".
- R2: With no fault armed on a bit, a write with `wrEn` high stores `wrData` at `addr` on the rising edge. In every cycle, `rdData` at the next edge shows the word at `addr` as it was before any write in that cycle, so reads take one cycle.
- R3: Fault code 1 is stuck-at-0. The target bit always reads 0, whatever was written to it before or after the fault was armed.
- R4: Fault code 2 is stuck-at-1. The target bit always reads 1, whatever was written to it before or after the fault was armed.
- R5: Fault code 3 is a failed rising transition. Writing 1 to a target bit that holds 0 leaves it at 0. Writing 0 to a bit that holds 1 stores 0, and writing the held value keeps it.
- R6: Fault code 4 is a failed falling transition. Writing 0 to a target bit that holds 1 leaves it at 1. Writing 1 to a bit that holds 0 stores 1, and writing the held value keeps it.
- R7: Fault code 5 is a destructive rewrite of 0. Writing 0 to a target bit that holds 0 makes it 1. All other writes to that bit store the written value.
- R8: Fault code 6 is a destructive rewrite of 1. Writing 1 to a target bit that holds 1 makes it 0. All other writes to that bit store the written value.
- R9: Only the bit at index `cfgBit` of the word at `cfgAddr` misbehaves. The other bits of that word, and all other words, behave as fault-free memory.
- R10: The fault code, word address and bit index are captured on a rising edge while `cfgValid` is high, and are held otherwise. A write in the same cycle as a capture uses the previous selection. Code 0 and code 7 both mean "no fault".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address for the write and the read |
| wrEn | input | 1 | Write strobe, active high |
| wrData | input | DATA_W | Data to write |
| rdData | output | DATA_W | Registered read data, one cycle after the address |
| cfgValid | input | 1 | Captures the fault selection on the next edge |
| cfgKind | input | 3 | Fault code: 0 none, 1 stuck-0, 2 stuck-1, 3 rise fails, 4 fall fails, 5 rewrite-0 flips, 6 rewrite-1 flips, 7 none |
| cfgAddr | input | ADDR_W | Word holding the faulty cell |
| cfgBit | input | BIT_W | Bit index of the faulty cell within that word |

## Verification
The hardest situations to reach are those where a fault only shows for one prior state of the cell. For example, a failed falling transition only appears when the cell already holds 1. The stimulus therefore preloads the target word with all zeros or all ones while no fault is armed, arms the fault, and then writes a sequence that walks the cell through both rewrites and both transitions. It reads back after every write. A second hard case is arming a fault in the same cycle as a write. The bench issues both on one edge and reads back to confirm that the write used the old selection.

// File: rtl/fault_ram_pkg.sv
package fault_ram_pkg;

  typedef enum logic [2:0] {
    FK_NONE = 3'd0,
    FK_SA0  = 3'd1,
    FK_SA1  = 3'd2,
    FK_TFUP = 3'd3,
    FK_TFDN = 3'd4,
    FK_WDF0 = 3'd5,
    FK_WDF1 = 3'd6,
    FK_RSVD = 3'd7
  } faultKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       wrHit;   // write addresses the faulty word, fault armed
    logic       rdHit;   // read addresses the faulty word, stuck fault armed
    faultKind_e kind;
  } cellStrobe_t;

  // stored value of the faulty bit after a write
  function automatic logic faultWriteBit(faultKind_e k, logic oldBit, logic newBit);
    logic res;
    res = newBit;
    case (k)
      FK_SA0:  res = 1'b0;
      FK_SA1:  res = 1'b1;
      FK_TFUP: res = (!oldBit && newBit) ? 1'b0 : newBit;
      FK_TFDN: res = (oldBit && !newBit) ? 1'b1 : newBit;
      FK_WDF0: res = (!oldBit && !newBit) ? 1'b1 : newBit;
      FK_WDF1: res = (oldBit && newBit) ? 1'b0 : newBit;
      default: res = newBit;
    endcase
    return res;
  endfunction

  function automatic logic isStuck(faultKind_e k);
    return (k == FK_SA0) || (k == FK_SA1);
  endfunction

endpackage

// File: rtl/fault_ram_ctrl.sv
module fault_ram_ctrl
  import fault_ram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgValid,
  input  logic [2:0]        cfgKind,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [BIT_W-1:0]  cfgBit,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output cellStrobe_t       strobe,
  output logic [BIT_W-1:0]  tgtBit
);

  faultKind_e        kindQ;
  logic [ADDR_W-1:0] tgtAddrQ;
  logic [BIT_W-1:0]  tgtBitQ;
  faultKind_e        kindIn;
  logic              armed;
  logic              addrMatch;

  // reserved code folds into "no fault"
  always_comb begin
    kindIn = faultKind_e'(cfgKind);
    if (kindIn == FK_RSVD) kindIn = FK_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ    <= FK_NONE;
      tgtAddrQ <= '0;
      tgtBitQ  <= '0;
    end else if (cfgValid) begin
      kindQ    <= kindIn;
      tgtAddrQ <= cfgAddr;
      tgtBitQ  <= cfgBit;
    end
  end

  assign armed     = (kindQ != FK_NONE);
  assign addrMatch = (addr == tgtAddrQ);

  always_comb begin
    strobe.wrHit = wrEn && armed && addrMatch;
    strobe.rdHit = addrMatch && isStuck(kindQ);
    strobe.kind  = kindQ;
  end

  assign tgtBit = tgtBitQ;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgValid |=> ($stable(strobe.kind) && $stable(tgtBit))) else $error("cfg changed without strobe"); // R10

  AST_RSVD_NONE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && cfgKind == 3'd7) |=> (strobe.kind == FK_NONE)) else $error("reserved code armed a fault"); // R10

  AST_NO_HIT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.kind == FK_NONE) |-> (!strobe.wrHit && !strobe.rdHit)) else $error("hit with no fault"); // R2

endmodule

// File: rtl/fault_ram_dp.sv
module fault_ram_dp
  import fault_ram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  cellStrobe_t       strobe,
  input  logic [BIT_W-1:0]  tgtBit,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] oldWord;
  logic [DATA_W-1:0] newWord;
  logic [DATA_W-1:0] readWord;

  assign oldWord = mem[addr];

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic sel;
    assign sel = (tgtBit == BIT_W'(b));
    assign newWord[b]  = (strobe.wrHit && sel) ?
                         faultWriteBit(strobe.kind, oldWord[b], wrData[b]) : wrData[b];
    assign readWord[b] = (strobe.rdHit && sel) ?
                         (strobe.kind == FK_SA1) : oldWord[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
      rdData <= '0;
    end else begin
      rdData <= readWord;
      if (wrEn) mem[addr] <= newWord;
    end
  end

  AST_PLAIN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !strobe.wrHit) |=> (mem[$past(addr)] == $past(wrData))) else $error("plain write lost"); // R2

  AST_SA0_READ: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdHit && strobe.kind == FK_SA0) |=> (rdData[$past(tgtBit)] == 1'b0)) else $error("stuck-0 read 1"); // R3

  AST_SA1_READ: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdHit && strobe.kind == FK_SA1) |=> (rdData[$past(tgtBit)] == 1'b1)) else $error("stuck-1 read 0"); // R4

  AST_TFUP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrHit && strobe.kind == FK_TFUP && !oldWord[tgtBit] && wrData[tgtBit])
    |=> (mem[$past(addr)][$past(tgtBit)] == 1'b0)) else $error("rise not blocked"); // R5

  AST_TFDN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrHit && strobe.kind == FK_TFDN && oldWord[tgtBit] && !wrData[tgtBit])
    |=> (mem[$past(addr)][$past(tgtBit)] == 1'b1)) else $error("fall not blocked"); // R6

  AST_WDF0_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrHit && strobe.kind == FK_WDF0 && !oldWord[tgtBit] && !wrData[tgtBit])
    |=> (mem[$past(addr)][$past(tgtBit)] == 1'b1)) else $error("rewrite-0 did not flip"); // R7

  AST_WDF1_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrHit && strobe.kind == FK_WDF1 && oldWord[tgtBit] && wrData[tgtBit])
    |=> (mem[$past(addr)][$past(tgtBit)] == 1'b0)) else $error("rewrite-1 did not flip"); // R8

  AST_OTHER_BITS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (((mem[$past(addr)] ^ $past(wrData)) & ~(DATA_W'(1) << $past(tgtBit))) == '0))
    else $error("non-target bit corrupted"); // R9

endmodule

// File: rtl/fault_ram.sv
module fault_ram
  import fault_ram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              cfgValid,
  input  logic [2:0]        cfgKind,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [BIT_W-1:0]  cfgBit
);

  cellStrobe_t      strobe;
  logic [BIT_W-1:0] tgtBit;

  fault_ram_ctrl #(.ADDR_W(ADDR_W), .BIT_W(BIT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgKind(cfgKind),
    .cfgAddr(cfgAddr), .cfgBit(cfgBit), .addr(addr), .wrEn(wrEn),
    .strobe(strobe), .tgtBit(tgtBit)
  );

  fault_ram_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_W(BIT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tgtBit(tgtBit), .addr(addr),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: tb/fault_ram_tb_top.sv
`timescale 1ns/1ps
module fault_ram_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] addr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       cfgValid = 1'b0;
  logic [2:0] cfgKind = '0;
  logic [3:0] cfgAddr = '0;
  logic [2:0] cfgBit = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] refMem [16];
  int refKind = 0;
  int refAddr = 0;
  int refBit = 0;

  always #5 clk = ~clk;

  fault_ram dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .cfgValid(cfgValid), .cfgKind(cfgKind),
    .cfgAddr(cfgAddr), .cfgBit(cfgBit)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic ruleBit(int k, logic o, logic w);
    case (k)
      1: return 1'b0;
      2: return 1'b1;
      3: return (o == 1'b0 && w == 1'b1) ? 1'b0 : w;
      4: return (o == 1'b1 && w == 1'b0) ? 1'b1 : w;
      5: return (o == 1'b0 && w == 1'b0) ? 1'b1 : w;
      6: return (o == 1'b1 && w == 1'b1) ? 1'b0 : w;
      default: return w;
    endcase
  endfunction

  function automatic logic [7:0] expRead(int a);
    logic [7:0] v = refMem[a];
    if (a == refAddr && refKind == 1) v[refBit] = 1'b0;
    if (a == refAddr && refKind == 2) v[refBit] = 1'b1;
    return v;
  endfunction

  function automatic void modelWrite(int a, logic [7:0] d);
    logic [7:0] v = d;
    if (a == refAddr) v[refBit] = ruleBit(refKind, refMem[a][refBit], d[refBit]);
    refMem[a] = v;
  endfunction

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    addr = 4'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic rdChk(string tag, int a);
    @(negedge clk);
    addr = 4'(a); wrEn = 1'b0;
    @(negedge clk);
    check(tag, rdData, expRead(a));
  endtask

  task automatic setCfg(int k, int a, int b);
    @(negedge clk);
    cfgValid = 1'b1; cfgKind = 3'(k); cfgAddr = 4'(a); cfgBit = 3'(b);
    @(negedge clk);
    cfgValid = 1'b0;
    refKind = (k == 7) ? 0 : k; refAddr = a; refBit = b;
  endtask

  task automatic testReset();
    for (int a = 0; a < 16; a++) rdChk("R1 reset contents", a);
  endtask

  task automatic testPlain();
    wr(5, 8'h11);
    wr(6, 8'hC3);
    rdChk("R2 plain readback", 5);
    rdChk("R2 plain readback", 6);
    // write and read same word in one cycle: old value returned
    @(negedge clk);
    addr = 4'd5; wrData = 8'h22; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    check("R2 read before write", rdData, 8'h11);
    modelWrite(5, 8'h22);
    rdChk("R2 new value", 5);
  endtask

  // preload with no fault, arm fault, walk the cell through writes
  task automatic runSeq(string tag, int k, int a, int b, logic [7:0] pre);
    logic [7:0] pat [7] = '{8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'hA5, 8'h5A};
    setCfg(0, 0, 0);
    wr(a, pre);
    setCfg(k, a, b);
    rdChk(tag, a);
    for (int i = 0; i < 7; i++) begin
      wr(a, pat[i]);
      rdChk(tag, a);
    end
    wr((a + 1) % 16, 8'h3C);
    rdChk("R9 neighbour word", (a + 1) % 16);
    wr((a + 1) % 16, 8'hC3);
    rdChk("R9 neighbour word", (a + 1) % 16);
    rdChk("R9 faulty word other bits", a);
  endtask

  task automatic testCfgTiming();
    setCfg(0, 0, 0);
    wr(9, 8'h00);
    // arm rise fault in the same cycle as a rising write: old selection applies
    @(negedge clk);
    addr = 4'd9; wrData = 8'h01; wrEn = 1'b1;
    cfgValid = 1'b1; cfgKind = 3'd3; cfgAddr = 4'd9; cfgBit = 3'd0;
    @(negedge clk);
    wrEn = 1'b0; cfgValid = 1'b0;
    modelWrite(9, 8'h01);
    refKind = 3; refAddr = 9; refBit = 0;
    rdChk("R10 same-cycle arm uses old cfg", 9);
    wr(9, 8'h00);
    wr(9, 8'h01);
    rdChk("R10 fault active after capture", 9);
    // code 7 behaves as no fault
    setCfg(7, 9, 0);
    wr(9, 8'h01);
    rdChk("R10 reserved code is no fault", 9);
    wr(9, 8'h00);
    rdChk("R10 reserved code is no fault", 9);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) refMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPlain();
    runSeq("R3 stuck-0", 1, 3, 2, 8'hFF);
    runSeq("R3 stuck-0", 1, 3, 2, 8'h00);
    runSeq("R4 stuck-1", 2, 7, 5, 8'h00);
    runSeq("R4 stuck-1", 2, 7, 5, 8'hFF);
    runSeq("R5 rise fails", 3, 10, 0, 8'h00);
    runSeq("R5 rise fails", 3, 10, 0, 8'hFF);
    runSeq("R6 fall fails", 4, 12, 7, 8'hFF);
    runSeq("R6 fall fails", 4, 12, 7, 8'h00);
    runSeq("R7 rewrite-0 flips", 5, 1, 3, 8'h00);
    runSeq("R7 rewrite-0 flips", 5, 1, 3, 8'hFF);
    runSeq("R8 rewrite-1 flips", 6, 15, 6, 8'hFF);
    runSeq("R8 rewrite-1 flips", 6, 15, 6, 8'h00);
    testCfgTiming();
    // reset mid-run clears contents and fault selection
    setCfg(2, 4, 1);
    wr(4, 8'h5A);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 16; i++) refMem[i] = 8'h00;
    refKind = 0;
    rdChk("R1 reset clears fault and data", 4);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule